// File: doc/BRIEF.md
# Latched Alarm Status Register

This block is the status and interrupt register of a framed line receiver, as seen by the control processor. The receive-side detectors drive it with single-cycle events and steady levels. There are two events: a new debounced line-overhead byte and a new debounced path-overhead byte. There are three alarm levels: path yellow, remote failure and protection-byte failure. A single-cycle counter-overflow event from the performance monitors also feeds it. The block records each of these in a sticky bit. It combines them into an interrupt summary bit, which also drives an interrupt line.

The processor reaches the register through a simple address/data bus, and three offsets give three views of it. Offset 0x0F2 returns the sticky bits, and reading it clears all of them. Offset 0x0F3 returns the same sticky bits but does not clear them on a read. Writing ones to 0x0F3 clears the chosen bits, so writing back a value just read clears everything that was reported. Offset 0x0F5 shows the live alarm levels, with nothing latched. Each alarm has a latch-mode input. The mode picks whether the alarm's sticky bit sets only when the level rises or on every change of the level.

Top module: `alarm_stat_reg`

## Requirements
- R1: While reset is asserted and just after it, every sticky bit and the overflow latch are zero, `irq_o` is low, and a read of 0x0F3 returns 0x00.
- R2: A pulse on `line_new_i` sets bit 6 and a pulse on `path_new_i` sets bit 5. Either bit is visible from the cycle after the pulse.
- R3: The alarm inputs map as follows: `alarm_lvl_i[2]` (path yellow) goes to bit 4, `alarm_lvl_i[1]` (remote failure) to bit 3, and `alarm_lvl_i[0]` (protection-byte failure) to bit 2. When `edge_mode_i[k]` is 0, bit k sets only on a 0-to-1 change of its level. When it is 1, the bit sets on any change of the level.
- R4: A read at 0x0F2 returns {bit7, bits 6..2, 2'b00} in the same cycle. From the next cycle on, all sticky bits, the overflow latch and `irq_o` are clear.
- R5: A read at 0x0F3 returns the same value as a read at 0x0F2 would, and clears nothing.
- R6: A write to 0x0F3 clears each of bits 7..2 whose data bit is 1. A data bit of 0 leaves its sticky bit unchanged. Writing the value just read clears every bit that was set. Writing 1 to bit 7 clears the overflow latch.
- R7: A read at 0x0F5 returns {3'b000, `alarm_lvl_i`, 2'b00}, the current levels with no latching.
- R8: A pulse on `pm_ovf_i` sets the overflow latch. Bit 7 and `irq_o` are high exactly when the overflow latch or any of bits 6..2 is set.
- R9: If a set event for a bit comes in the same cycle as a clear of that bit (a read of 0x0F2 or a write-one to 0x0F3), the bit ends up set.
- R10: Bits 1..0 always read 0. `rdata_o` is 0 when `rd_en_i` is low or the address is any other offset. Reads and writes at other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_new_i | input | 1 | Pulse: new debounced line-overhead byte |
| path_new_i | input | 1 | Pulse: new debounced path-overhead byte |
| pm_ovf_i | input | 1 | Pulse: performance-monitor counter overflow |
| alarm_lvl_i | input | 3 | Alarm levels: [2] path yellow, [1] remote failure, [0] protection-byte failure |
| edge_mode_i | input | 3 | Per-alarm latch mode: 0 rising edge only, 1 both edges |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_en_i` |
| irq_o | output | 1 | Interrupt summary, held until cleared |

## Verification
A missed or misrouted edge capture shows up as a wrong bit in the next read of 0x0F3, and as a wrong `irq_o` one cycle after the event. A clear that reaches too far or not far enough shows in the read that follows a 0x0F2 read or a 0x0F3 write. When a set and a clear collide, a wrong priority leaves a reported event missing on the very next cycle. Because the live view at 0x0F5 holds no state, any fault there is visible in the same cycle as the read.

// File: rtl/alarm_stat_pkg.sv
package alarm_stat_pkg;
  localparam int DATA_W  = 8;
  localparam int N_ALM   = 3;   // alarm levels
  localparam int N_EVT   = 5;   // sticky bits 6..2
  localparam int LAT_LSB = 2;   // bit position of lowest sticky bit
  localparam int N_BANK  = N_EVT + 1; // sticky bits plus overflow latch

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_BOTH = 1'b1} edge_mode_e;

  // event seen on an alarm level given the selected latch mode
  function automatic logic edge_hit(logic mode, logic cur, logic prev);
    return mode ? (cur ^ prev) : (cur & ~prev);
  endfunction

  // sticky bit next state: a set outranks a clear in the same cycle
  function automatic logic latch_next(logic q, logic set, logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/alarm_edge_det.sv
module alarm_edge_det
  import alarm_stat_pkg::*;
#(
  parameter int N = N_ALM
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] mode_i,
  output logic [N-1:0] hit_o
);
  logic [N-1:0] prev_q;

  for (genvar k = 0; k < N; k++) begin : g_alm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[k] <= 1'b0;
      else        prev_q[k] <= lvl_i[k];
    end
    assign hit_o[k] = edge_hit(mode_i[k], lvl_i[k], prev_q[k]);
  end
endmodule

// File: rtl/stat_latch_bank.sv
module stat_latch_bank
  import alarm_stat_pkg::*;
#(
  parameter int W = N_BANK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[b] <= 1'b0;
      else        q_o[b] <= latch_next(q_o[b], set_i[b], clr_i[b]);
    end
  end
endmodule

// File: rtl/stat_bus_dec.sv
module stat_bus_dec
  import alarm_stat_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] OFS_COR = 12'h0F2,
  parameter logic [11:0] OFS_W1C = 12'h0F3,
  parameter logic [11:0] OFS_LIV = 12'h0F5
) (
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sum_i,
  input  logic [N_EVT-1:0]  lat_i,
  input  logic [N_ALM-1:0]  lvl_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cor_clr_o,
  output logic [DATA_W-1:0] w1c_o
);
  localparam logic [ADDR_W-1:0] A_COR = ADDR_W'(OFS_COR);
  localparam logic [ADDR_W-1:0] A_W1C = ADDR_W'(OFS_W1C);
  localparam logic [ADDR_W-1:0] A_LIV = ADDR_W'(OFS_LIV);

  logic [DATA_W-1:0] latched_view;
  logic [DATA_W-1:0] live_view;

  assign latched_view = {sum_i, lat_i, {LAT_LSB{1'b0}}};
  assign live_view    = {{(DATA_W-N_ALM-LAT_LSB){1'b0}}, lvl_i, {LAT_LSB{1'b0}}};

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == A_COR || addr_i == A_W1C) rdata_o = latched_view;
      else if (addr_i == A_LIV)               rdata_o = live_view;
    end
  end

  assign cor_clr_o = rd_en_i && (addr_i == A_COR);
  assign w1c_o     = (wr_en_i && (addr_i == A_W1C)) ? wdata_i : '0;
endmodule

// File: rtl/alarm_stat_reg.sv
module alarm_stat_reg
  import alarm_stat_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] OFS_COR = 12'h0F2,
  parameter logic [11:0] OFS_W1C = 12'h0F3,
  parameter logic [11:0] OFS_LIV = 12'h0F5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_new_i,
  input  logic              path_new_i,
  input  logic              pm_ovf_i,
  input  logic [N_ALM-1:0]  alarm_lvl_i,
  input  logic [N_ALM-1:0]  edge_mode_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  // named internal events, observed by the bound checker
  logic [N_ALM-1:0]  alm_hit;
  logic [N_EVT-1:0]  set_vec;
  logic              cor_clr;
  logic [DATA_W-1:0] w1c_vec;
  logic [N_BANK-1:0] bank_set, bank_clr, bank_q;
  logic [N_EVT-1:0]  lat_q;
  logic              ovf_q;
  logic              sum_bit;

  alarm_edge_det #(.N(N_ALM)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (alarm_lvl_i),
    .mode_i (edge_mode_i),
    .hit_o  (alm_hit)
  );

  // sticky index 4..0 = register bits 6..2
  assign set_vec  = {line_new_i, path_new_i, alm_hit};
  assign bank_set = {pm_ovf_i, set_vec};
  assign bank_clr = {N_BANK{cor_clr}} | w1c_vec[DATA_W-1:LAT_LSB];

  stat_latch_bank #(.W(N_BANK)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (bank_set),
    .clr_i (bank_clr),
    .q_o   (bank_q)
  );

  assign lat_q   = bank_q[N_EVT-1:0];
  assign ovf_q   = bank_q[N_BANK-1];
  assign sum_bit = ovf_q | (|lat_q);
  assign irq_o   = sum_bit;

  stat_bus_dec #(
    .ADDR_W (ADDR_W),
    .OFS_COR(OFS_COR),
    .OFS_W1C(OFS_W1C),
    .OFS_LIV(OFS_LIV)
  ) u_dec (
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .sum_i    (sum_bit),
    .lat_i    (lat_q),
    .lvl_i    (alarm_lvl_i),
    .rdata_o  (rdata_o),
    .cor_clr_o(cor_clr),
    .w1c_o    (w1c_vec)
  );
endmodule

// File: rtl/alarm_stat_reg_chk.sv
module alarm_stat_reg_chk
  import alarm_stat_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] OFS_COR = 12'h0F2,
  parameter logic [11:0] OFS_W1C = 12'h0F3,
  parameter logic [11:0] OFS_LIV = 12'h0F5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_new_i,
  input logic              path_new_i,
  input logic              pm_ovf_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [N_EVT-1:0]  lat_q,
  input logic              ovf_q,
  input logic [N_EVT-1:0]  set_vec,
  input logic              cor_clr
);
  localparam logic [ADDR_W-1:0] A_W1C = ADDR_W'(OFS_W1C);
  localparam logic [ADDR_W-1:0] A_LIV = ADDR_W'(OFS_LIV);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (lat_q == '0 && !ovf_q));

  p_line_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_new_i |=> lat_q[4]);

  p_path_new_r2: assert property (@(posedge clk) disable iff (!rst_n)
    path_new_i |=> lat_q[3]);

  p_cor_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_clr && set_vec == '0 && !pm_ovf_i) |=> (lat_q == '0 && !ovf_q && !irq_o));

  p_w1c_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !wr_en_i && addr_i == A_W1C) |=> (($past(lat_q) & ~lat_q) == '0));

  p_live_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_LIV) |-> (rdata_o[7:5] == 3'b000));

  p_ovf_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pm_ovf_i |=> irq_o);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_clr && (|set_vec)) |=> (lat_q != '0));

  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[1:0] == 2'b00);
endmodule

bind alarm_stat_reg alarm_stat_reg_chk #(
  .ADDR_W (ADDR_W),
  .OFS_COR(OFS_COR),
  .OFS_W1C(OFS_W1C),
  .OFS_LIV(OFS_LIV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_new_i(line_new_i),
  .path_new_i(path_new_i),
  .pm_ovf_i  (pm_ovf_i),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .lat_q     (lat_q),
  .ovf_q     (ovf_q),
  .set_vec   (set_vec),
  .cor_clr   (cor_clr)
);

// File: tb/alarm_stat_reg_tb.sv
module alarm_stat_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_COR = 12'h0F2;
  localparam logic [11:0] A_W1C = 12'h0F3;
  localparam logic [11:0] A_LIV = 12'h0F5;
  localparam logic [11:0] A_GAP = 12'h0F4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_new = 0, path_new = 0, pm_ovf = 0;
  logic [2:0] lvl = '0, mode = '0;
  logic rd = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model: m_bits[6:2] sticky, m_ovf overflow latch, m_prev alarm history
  logic [7:0] m_bits = '0;
  logic m_ovf = 0;
  logic [2:0] m_prev = '0;
  logic [7:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_stat_reg dut_i (
    .clk(clk), .rst_n(rst_n),
    .line_new_i(line_new), .path_new_i(path_new), .pm_ovf_i(pm_ovf),
    .alarm_lvl_i(lvl), .edge_mode_i(mode),
    .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic m_sum();
    return m_ovf || (m_bits[6:2] != 5'b0);
  endfunction

  function automatic logic [7:0] m_read(logic [11:0] a);
    if (a == A_COR || a == A_W1C) return {m_sum(), m_bits[6:2], 2'b00};
    if (a == A_LIV) return {3'b000, lvl, 2'b00};
    return 8'h00;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    if (a == A_COR) return "R4";
    if (a == A_W1C) return "R5";
    if (a == A_LIV) return "R7";
    return "R10";
  endfunction

  // one bus cycle; inputs driven after the falling edge, results sampled before the rising edge
  task automatic step(input logic ln, input logic pn, input logic ov, input logic [2:0] lv,
                      input logic r, input logic w, input logic [11:0] a, input logic [7:0] wd);
    logic [7:0] set_b, clr_b;
    line_new = ln; path_new = pn; pm_ovf = ov; lvl = lv;
    rd = r; wr = w; addr = a; wdata = wd;
    #1;
    last_rd = rdata;
    if (r) chk(rdata, m_read(a), tag_of(a));
    else   chk(rdata, 8'h00, "R10");
    set_b = '0;
    set_b[6] = ln;
    set_b[5] = pn;
    for (int k = 0; k < 3; k++) begin
      if (mode[k]) set_b[2+k] = (lv[k] != m_prev[k]);
      else         set_b[2+k] = lv[k] && !m_prev[k];
    end
    clr_b = (r && a == A_COR) ? 8'hFF : 8'h00;
    if (w && a == A_W1C) clr_b = clr_b | wd;
    @(posedge clk);
    for (int b = 2; b < 7; b++) begin
      if (set_b[b]) m_bits[b] = 1'b1;
      else if (clr_b[b]) m_bits[b] = 1'b0;
    end
    if (ov) m_ovf = 1'b1;
    else if (clr_b[7]) m_ovf = 1'b0;
    m_prev = lv;
    @(negedge clk);
    chk({7'b0, irq}, {7'b0, m_sum()}, "R8");
    line_new = 0; path_new = 0; pm_ovf = 0; rd = 0; wr = 0;
  endtask

  task automatic rd_at(input logic [11:0] a);
    step(0, 0, 0, lvl, 1, 0, a, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk({7'b0, irq}, 8'h00, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    rd_at(A_W1C); chk(last_rd, 8'h00, "R1");

    // R2: new-byte events
    step(1, 0, 0, 3'b000, 0, 0, A_GAP, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'hC0, "R2");
    step(0, 1, 0, 3'b000, 0, 0, A_GAP, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'hE0, "R2");
    rd_at(A_W1C); chk(last_rd, 8'hE0, "R5");

    // R4: clear-on-read
    rd_at(A_COR); chk(last_rd, 8'hE0, "R4");
    rd_at(A_W1C); chk(last_rd, 8'h00, "R4");
    chk({7'b0, irq}, 8'h00, "R4");

    // R3: rising-only mode on protection failure (bit 2)
    mode = 3'b000;
    step(0, 0, 0, 3'b001, 0, 0, A_GAP, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'h84, "R3");
    step(0, 0, 0, 3'b001, 0, 1, A_W1C, 8'h04);
    step(0, 0, 0, 3'b000, 0, 0, A_GAP, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'h00, "R3");
    // R3: both-edge mode on remote failure (bit 3)
    mode = 3'b010;
    step(0, 0, 0, 3'b010, 0, 0, A_GAP, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'h88, "R3");
    step(0, 0, 0, 3'b010, 0, 1, A_W1C, 8'h08);
    rd_at(A_W1C); chk(last_rd, 8'h00, "R3");
    step(0, 0, 0, 3'b000, 0, 0, A_GAP, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'h88, "R3");
    // path yellow (bit 4)
    step(0, 0, 0, 3'b100, 0, 0, A_GAP, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'h98, "R3");

    // R6: zeros leave bits, write-back clears all
    step(0, 0, 0, 3'b100, 0, 1, A_W1C, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'h98, "R6");
    step(0, 0, 0, 3'b100, 0, 1, A_W1C, last_rd);
    rd_at(A_W1C); chk(last_rd, 8'h00, "R6");

    // R7: live view
    step(0, 0, 0, 3'b101, 1, 0, A_LIV, 8'h00); chk(last_rd, 8'h14, "R7");
    step(0, 0, 0, 3'b000, 1, 0, A_LIV, 8'h00); chk(last_rd, 8'h00, "R7");
    rd_at(A_COR);

    // R8: overflow latch drives bit 7 and irq
    step(0, 0, 1, 3'b000, 0, 0, A_GAP, 8'h00);
    chk({7'b0, irq}, 8'h01, "R8");
    rd_at(A_W1C); chk(last_rd, 8'h80, "R8");
    step(0, 0, 0, 3'b000, 0, 1, A_W1C, 8'h80);
    rd_at(A_W1C); chk(last_rd, 8'h00, "R8");

    // R9: set beats clear
    step(1, 0, 0, 3'b000, 1, 0, A_COR, 8'h00);
    rd_at(A_W1C); chk(last_rd, 8'hC0, "R9");
    step(1, 0, 0, 3'b000, 0, 1, A_W1C, 8'h40);
    rd_at(A_W1C); chk(last_rd, 8'hC0, "R9");

    // R10: other offsets have no effect
    step(0, 0, 0, 3'b000, 0, 1, A_GAP, 8'hFF);
    rd_at(A_GAP); chk(last_rd, 8'h00, "R10");
    rd_at(A_W1C); chk(last_rd, 8'hC0, "R10");

    // random mix, compared against the bench model
    for (int i = 0; i < 800; i++) begin
      logic [11:0] a;
      logic [1:0] sel;
      if ($urandom_range(0, 15) == 0) mode = 3'($urandom);
      sel = 2'($urandom);
      a = (sel == 0) ? A_COR : (sel == 1) ? A_W1C : (sel == 2) ? A_LIV : A_GAP;
      step(($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), ($urandom_range(0, 15) == 0),
           ($urandom_range(0, 3) == 0) ? 3'($urandom) : lvl,
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 3) == 0), a, 8'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule